// File: doc/BRIEF.md
# VGA Test Pattern Generator

This block drives a 640x480 display from a 25 MHz pixel clock (40 ns per pixel). It produces three 8-bit colour channels, active-low horizontal and vertical sync, horizontal and vertical blank flags, and a packed 8-bit port that carries the top two bits of each colour together with both syncs. It is meant for checking a display path or a set of video DACs. The ramps it can produce step by one level per pixel, per line or per frame.

The pattern is picked by a mode byte. The byte is sampled on every clock edge while reset is held low, and the last value sampled stays in force once reset is released. Three ramp-family modes are available: a grey ramp, a colour ramp and an inverted-bar ramp. Each ramp-family mode ends every visible line with a 16-pixel binary stamp of the current line number. A pass-through mode copies the live input byte to all three channels, either gated to the visible area or ungated. Any other mode value gives a black screen.

Top module: `vga_test_pattern_gen`

## Requirements
- R1: The mode byte is captured while rst_ni is low. After reset is released, changes on mode_i do not alter the selected pattern.
- R2: Each line is H_VIS+H_FP+H_SYNC+H_BP clocks long (default 640+16+96+48) and each frame has V_VIS+V_FP+V_SYNC+V_BP lines (default 480+10+2+33). Both counters start at 0 after reset. hsync_o is low for columns H_VIS+H_FP up to H_VIS+H_FP+H_SYNC-1. vsync_o is low for lines V_VIS+V_FP up to V_VIS+V_FP+V_SYNC-1. blank_o[0] is high when line >= V_VIS, and blank_o[1] is high when column >= H_VIS.
- R3: In mode 8'h13, all three channels equal column mod 256.
- R4: In mode 8'h10, red is column mod 256, green is line mod 256, and blue is a frame count mod 256. The frame count is 0 after reset and increases by one after the last clock of each frame.
- R5: Mode 8'h20 gives the mode 8'h10 values, except that every channel is bitwise inverted on odd columns.
- R6: In modes 8'h10, 8'h13 and 8'h20, visible columns H_VIS-16 to H_VIS-1 show the line number as 16 bits, most significant bit at the leftmost pixel. All three channels are 8'hFF for a 1 bit and 8'h00 for a 0 bit. The stamp takes priority over the odd-column inversion.
- R7: Outside the visible area all three channels are 0 in every mode, except ungated pass-through.
- R8: In mode 8'h00, every channel equals the live mode_i byte. When mode_i[1] is 1, the channels are 0 outside the visible area. When mode_i[1] is 0, they are not gated.
- R9: Any mode value other than 8'h00, 8'h10, 8'h13 and 8'h20 outputs 0 on all channels.
- R10: vga_o holds, from bit 0 to bit 7: red[7], green[7], blue[7], vsync, red[6], green[6], blue[6], hsync.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Pixel clock |
| rst_ni | input | 1 | Active-low asynchronous reset; mode is captured while low |
| mode_i | input | 8 | Mode byte during reset; live data in pass-through |
| red_o | output | 8 | Red channel |
| green_o | output | 8 | Green channel |
| blue_o | output | 8 | Blue channel |
| hsync_o | output | 1 | Horizontal sync, active low |
| vsync_o | output | 1 | Vertical sync, active low |
| blank_o | output | 2 | Bit 0 vertical blank, bit 1 horizontal blank |
| vga_o | output | 8 | Packed 2-bit-per-colour port with syncs |

## Verification
Two functions can act on the same pixel. In the bar mode, the line-number stamp and the odd-column inversion both claim the last 16 columns, and half of those columns are odd. The bench runs a full bar-mode frame, and its reference model expects the stamp value, never inverted, on those columns. A second pair of functions meets at the pass-through edges. Blank gating and the live data bit that controls gating change on the same clock there, so the bench changes the input byte on every clock and checks each blanking pixel against the gating bit of that same cycle.

// File: rtl/vga_pat_pkg.sv
package vga_pat_pkg;
  localparam logic [7:0] MODE_PASS = 8'h00;
  localparam logic [7:0] MODE_RAMP = 8'h10;
  localparam logic [7:0] MODE_GREY = 8'h13;
  localparam logic [7:0] MODE_BARS = 8'h20;

  typedef struct packed {
    logic [7:0] r;
    logic [7:0] g;
    logic [7:0] b;
  } rgb_t;

  function automatic logic is_ramp_family(input logic [7:0] m);
    return (m == MODE_RAMP) || (m == MODE_GREY) || (m == MODE_BARS);
  endfunction
endpackage

// File: rtl/vga_timing.sv
module vga_timing #(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33,
  parameter int HW     = 10,
  parameter int VW     = 10
) (
  input  logic          clk_i,
  input  logic          rst_ni,
  output logic [HW-1:0] col_o,
  output logic [VW-1:0] line_o,
  output logic [7:0]    frame_o,
  output logic          hvis_o,
  output logic          vvis_o,
  output logic          hsync_o,
  output logic          vsync_o
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HS_BEG  = H_VIS + H_FP;
  localparam int HS_END  = HS_BEG + H_SYNC;
  localparam int VS_BEG  = V_VIS + V_FP;
  localparam int VS_END  = VS_BEG + V_SYNC;

  logic [HW-1:0] col_q;
  logic [VW-1:0] line_q;
  logic [7:0]    frame_q;
  logic          col_last, line_last;

  assign col_last  = (col_q == HW'(H_TOTAL - 1));
  assign line_last = (line_q == VW'(V_TOTAL - 1));

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      col_q   <= '0;
      line_q  <= '0;
      frame_q <= '0;
    end else if (col_last) begin
      col_q <= '0;
      if (line_last) begin
        line_q  <= '0;
        frame_q <= frame_q + 8'd1;
      end else begin
        line_q <= line_q + VW'(1);
      end
    end else begin
      col_q <= col_q + HW'(1);
    end
  end

  assign col_o   = col_q;
  assign line_o  = line_q;
  assign frame_o = frame_q;
  assign hvis_o  = (col_q < HW'(H_VIS));
  assign vvis_o  = (line_q < VW'(V_VIS));
  assign hsync_o = !((col_q >= HW'(HS_BEG)) && (col_q < HW'(HS_END)));
  assign vsync_o = !((line_q >= VW'(VS_BEG)) && (line_q < VW'(VS_END)));

  assert_col_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_q < HW'(H_TOTAL));
  assert_line_range_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    line_q < VW'(V_TOTAL));
  assert_col_wrap_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    col_last |=> (col_q == '0));
  assert_line_hold_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !col_last |=> $stable(line_q));
  assert_frame_step_R4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(col_last && line_last) |=> $stable(frame_q));
  assert_hsync_in_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !hsync_o |-> !hvis_o);
  assert_vsync_in_blank_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !vsync_o |-> !vvis_o);
endmodule

// File: rtl/vga_pattern.sv
module vga_pattern
  import vga_pat_pkg::*;
#(
  parameter int H_VIS = 640,
  parameter int HW    = 10,
  parameter int VW    = 10
) (
  input  logic [7:0]    mode_i,
  input  logic [7:0]    live_i,
  input  logic [HW-1:0] col_i,
  input  logic [VW-1:0] line_i,
  input  logic [7:0]    frame_i,
  input  logic          vis_i,
  output rgb_t          pix_o,
  output logic          stamp_o
);
  localparam int STAMP_W   = 16;
  localparam int STAMP_BEG = H_VIS - STAMP_W;

  logic [HW-1:0] stamp_off;
  logic [15:0]   line16;
  logic          stamp_bit, stamp_zone, pass_open;
  rgb_t          base;

  assign line16     = 16'(line_i);
  assign stamp_off  = col_i - HW'(STAMP_BEG);
  assign stamp_bit  = line16[~stamp_off[3:0]];
  assign stamp_zone = vis_i && (col_i >= HW'(STAMP_BEG)) && is_ramp_family(mode_i);
  assign pass_open  = (mode_i == MODE_PASS) && !live_i[1];

  always_comb begin
    base = '0;
    unique case (mode_i)
      MODE_GREY: base = '{r: 8'(col_i), g: 8'(col_i), b: 8'(col_i)};
      MODE_RAMP: base = '{r: 8'(col_i), g: 8'(line_i), b: frame_i};
      MODE_BARS: begin
        base = '{r: 8'(col_i), g: 8'(line_i), b: frame_i};
        if (col_i[0]) base = ~base;
      end
      MODE_PASS: base = '{r: live_i, g: live_i, b: live_i};
      default:   base = '0;
    endcase
  end

  always_comb begin
    if (stamp_zone)
      pix_o = {24{stamp_bit}};
    else if (vis_i || pass_open)
      pix_o = base;
    else
      pix_o = '0;
  end

  assign stamp_o = stamp_zone;
endmodule

// File: rtl/vga_test_pattern_gen.sv
module vga_test_pattern_gen
  import vga_pat_pkg::*;
#(
  parameter int H_VIS  = 640,
  parameter int H_FP   = 16,
  parameter int H_SYNC = 96,
  parameter int H_BP   = 48,
  parameter int V_VIS  = 480,
  parameter int V_FP   = 10,
  parameter int V_SYNC = 2,
  parameter int V_BP   = 33
) (
  input  logic       clk_i,
  input  logic       rst_ni,
  input  logic [7:0] mode_i,
  output logic [7:0] red_o,
  output logic [7:0] green_o,
  output logic [7:0] blue_o,
  output logic       hsync_o,
  output logic       vsync_o,
  output logic [1:0] blank_o,
  output logic [7:0] vga_o
);
  localparam int H_TOTAL = H_VIS + H_FP + H_SYNC + H_BP;
  localparam int V_TOTAL = V_VIS + V_FP + V_SYNC + V_BP;
  localparam int HW      = $clog2(H_TOTAL);
  localparam int VW      = $clog2(V_TOTAL);

  logic [7:0]    mode_q;
  logic [HW-1:0] col;
  logic [VW-1:0] line;
  logic [7:0]    frame;
  logic          hvis, vvis, vis, hs, vs, in_stamp;
  rgb_t          pix;

  // Async load: follows mode_i at every edge while reset is held
  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) mode_q <= mode_i;
    else         mode_q <= mode_q;
  end

  vga_timing #(
    .H_VIS(H_VIS), .H_FP(H_FP), .H_SYNC(H_SYNC), .H_BP(H_BP),
    .V_VIS(V_VIS), .V_FP(V_FP), .V_SYNC(V_SYNC), .V_BP(V_BP),
    .HW(HW), .VW(VW)
  ) u_timing (
    .clk_i   (clk_i),
    .rst_ni  (rst_ni),
    .col_o   (col),
    .line_o  (line),
    .frame_o (frame),
    .hvis_o  (hvis),
    .vvis_o  (vvis),
    .hsync_o (hs),
    .vsync_o (vs)
  );

  assign vis = hvis && vvis;

  vga_pattern #(.H_VIS(H_VIS), .HW(HW), .VW(VW)) u_pattern (
    .mode_i  (mode_q),
    .live_i  (mode_i),
    .col_i   (col),
    .line_i  (line),
    .frame_i (frame),
    .vis_i   (vis),
    .pix_o   (pix),
    .stamp_o (in_stamp)
  );

  assign red_o   = pix.r;
  assign green_o = pix.g;
  assign blue_o  = pix.b;
  assign hsync_o = hs;
  assign vsync_o = vs;
  assign blank_o = {!hvis, !vvis};
  assign vga_o   = {hs, pix.b[6], pix.g[6], pix.r[6], vs, pix.b[7], pix.g[7], pix.r[7]};

  assert_mode_held_R1: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $past(rst_ni) |-> $stable(mode_q));
  assert_blank_black_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (!vis && !(mode_q == MODE_PASS && !mode_i[1])) |-> (pix == '0));
  assert_stamp_level_R6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    in_stamp |-> ((pix == '0) || (pix == '1)));
  assert_unlisted_black_R9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (mode_q != MODE_PASS && !is_ramp_family(mode_q)) |-> (pix == '0));
endmodule

// File: tb/tb_vga_test_pattern_gen.sv
module tb_vga_test_pattern_gen;
  localparam int CLK_PERIOD = 40;
  localparam int HV = 640, HF = 16, HS = 96, HB = 48;
  localparam int VV = 20, VF = 2, VS = 2, VB = 3;
  localparam int HT = HV + HF + HS + HB;
  localparam int VT = VV + VF + VS + VB;

  typedef struct {
    logic [7:0] r, g, b;
    logic       hs, vs;
    logic [1:0] blank;
    logic [7:0] vga;
    string      req;
  } item_t;

  logic       clk = 1'b0;
  logic       rst_ni = 1'b0;
  logic [7:0] mode_i = 8'h00;
  logic [7:0] red_o, green_o, blue_o, vga_o;
  logic       hsync_o, vsync_o;
  logic [1:0] blank_o;

  int checks = 0;
  int failures = 0;
  int mh = 0, mv = 0, mf = 0;
  logic [7:0] cur_mode = 8'h00;
  item_t q[$];

  always #(CLK_PERIOD / 2) clk = ~clk;

  vga_test_pattern_gen #(
    .H_VIS(HV), .H_FP(HF), .H_SYNC(HS), .H_BP(HB),
    .V_VIS(VV), .V_FP(VF), .V_SYNC(VS), .V_BP(VB)
  ) dut (
    .clk_i(clk), .rst_ni(rst_ni), .mode_i(mode_i),
    .red_o(red_o), .green_o(green_o), .blue_o(blue_o),
    .hsync_o(hsync_o), .vsync_o(vsync_o), .blank_o(blank_o), .vga_o(vga_o)
  );

  function automatic item_t model(input logic [7:0] m, input logic [7:0] live);
    item_t it;
    logic vis, ramp, stamp;
    logic [15:0] ln;
    int k;
    vis  = (mh < HV) && (mv < VV);
    ramp = (m == 8'h10) || (m == 8'h13) || (m == 8'h20);
    stamp = vis && ramp && (mh >= HV - 16);
    ln = 16'(mv);
    it.r = 0; it.g = 0; it.b = 0;
    if (stamp) begin
      k = mh - (HV - 16);
      it.r = ln[15 - k] ? 8'hFF : 8'h00;
      it.g = it.r; it.b = it.r;
      it.req = "R6";
    end else if (m == 8'h00) begin
      if (vis || !live[1]) begin it.r = live; it.g = live; it.b = live; end
      it.req = "R8";
    end else if (!vis) begin
      it.req = "R7";
    end else if (m == 8'h13) begin
      it.r = 8'(mh); it.g = 8'(mh); it.b = 8'(mh);
      it.req = "R3";
    end else if (m == 8'h10 || m == 8'h20) begin
      it.r = 8'(mh); it.g = 8'(mv); it.b = 8'(mf);
      it.req = "R4";
      if (m == 8'h20) begin
        it.req = "R5";
        if (mh % 2 == 1) begin it.r = ~it.r; it.g = ~it.g; it.b = ~it.b; end
      end
    end else begin
      it.req = "R9";
    end
    it.hs = !((mh >= HV + HF) && (mh < HV + HF + HS));
    it.vs = !((mv >= VV + VF) && (mv < VV + VF + VS));
    it.blank = {mh >= HV, mv >= VV};
    it.vga = {it.hs, it.b[6], it.g[6], it.r[6], it.vs, it.b[7], it.g[7], it.r[7]};
    return it;
  endfunction

  task automatic step_model();
    mh++;
    if (mh == HT) begin
      mh = 0; mv++;
      if (mv == VT) begin mv = 0; mf = (mf + 1) % 256; end
    end
  endtask

  task automatic check(input bit ok, input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s at col=%0d line=%0d: actual=%h expected=%h",
               req, what, mh, mv, act, exp);
    end
  endtask

  // Monitor: pops expected items and compares against the ports
  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      item_t it;
      it = q.pop_front();
      check({red_o, green_o, blue_o} === {it.r, it.g, it.b}, it.req, "rgb",
            {8'h0, red_o, green_o, blue_o}, {8'h0, it.r, it.g, it.b});
      check({hsync_o, vsync_o, blank_o} === {it.hs, it.vs, it.blank}, "R2", "sync/blank",
            {28'h0, hsync_o, vsync_o, blank_o}, {28'h0, it.hs, it.vs, it.blank});
      check(vga_o === it.vga, "R10", "vga", {24'h0, vga_o}, {24'h0, it.vga});
    end
  end

  task automatic do_reset(input logic [7:0] m);
    @(negedge clk);
    rst_ni = 1'b0;
    mode_i = m;
    cur_mode = m;
    mh = 0; mv = 0; mf = 0;
    repeat (3) @(negedge clk);
    #2;
    check(hsync_o === 1'b1 && vsync_o === 1'b1 && blank_o === 2'b00, "R2", "reset state",
          {29'h0, hsync_o, blank_o}, 32'h4);
    @(negedge clk);
    rst_ni = 1'b1;
  endtask

  // kind: 0 hold mode_i, 1 scramble mode_i (R1), 2 live pass-through byte (R8)
  task automatic drive(input int n, input int kind);
    for (int i = 0; i < n; i++) begin
      if (i > 0) @(negedge clk);
      if (kind == 1) mode_i = 8'(i * 37) ^ 8'h5A;
      else if (kind == 2) mode_i = 8'(i * 7 + 3);
      q.push_back(model(cur_mode, mode_i));
      step_model();
    end
  endtask

  initial begin
    do_reset(8'h10);
    drive(2 * HT * VT + 900, 1);   // R1, R4, R6 across two frame wraps
    do_reset(8'h13);
    drive(HT * VT, 0);             // R3
    do_reset(8'h20);
    drive(HT * VT, 0);             // R5 with R6 overlap on odd columns
    do_reset(8'h00);
    drive(HT * VT, 2);             // R8 gated and ungated, R7
    do_reset(8'h55);
    drive(2 * HT, 0);              // R9
    @(negedge clk);
    #5;
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (190000) @(posedge clk);
    failures++;
    $display("FAIL watchdog: run did not finish, actual=hung expected=done");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end
endmodule